// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits beside a byte-wide Ethernet receiver and decides, for each incoming frame, whether the frame is kept or dropped. It watches the receive byte stream. When the receiver reports that it is in the preamble phase and the current byte is the start-of-frame delimiter 0xD5, the block starts classifying the six destination-address bytes that follow. Several byte-serial matchers run side by side on those bytes:

- two exact matchers compare against programmable unicast and multicast addresses;
- two exact matchers compare against the fixed broadcast and pause addresses;
- one matcher recognises any individual (non-group) address.

A per-class pass mask in a small settings register chooses which matches lead to a keep. The block produces a single-cycle decision strobe that carries the keep flag. The mask and the programmable addresses are taken as a snapshot when a frame starts, so changes made during a frame apply only to later frames. A new start-of-frame abandons any comparison that is still running.

The register bank sits on a simple single-cycle-acknowledge bus. The word index is taken from address bits 7:2. The two settings bits that control pause handling elsewhere in the MAC are passed straight out to ports.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, frame_valid and frame_keep are 0 and the settings register holds 7'b0111011, so cfg_pause_send_en is 0 and cfg_pause_obey_en is 1. Both programmable addresses reset to zero.
- R2: A frame starts only when rx_in_preamble is 1 and rx_byte is 0xD5 in the same cycle. The next six bytes are the destination address, most significant byte first. A 0xD5 byte seen while rx_in_preamble is 0 produces no decision.
- R3: Each started frame gives one decision. frame_valid is high for exactly one cycle, the cycle after the 7th rising edge that follows the edge sampling the 0xD5 byte. frame_keep is 1 only while frame_valid is 1.
- R4: With settings bit 1 (pass individual) set, a frame is kept whenever bit 0 of the first destination byte is 0, whatever the other address bits are.
- R5: With settings bit 3 (pass broadcast) set, destination FF:FF:FF:FF:FF:FF is kept, and a single differing bit is not treated as broadcast.
- R6: With settings bit 2 (pass pause) set, destination 01:80:C2:00:00:01 is kept.
- R7: With settings bit 5 (pass unicast) set, a destination equal to the unicast address is kept. Word index 1 holds address bits 47:32 and index 2 holds bits 31:0. A mismatch in any byte means no unicast match.
- R8: With settings bit 4 (pass multicast) set, a destination equal to the multicast address is kept. Word index 3 holds address bits 47:32 and index 4 holds bits 31:0.
- R9: keep is the OR over the five classes of (class enabled AND class matched). A match in a disabled class does not keep the frame, and a group address (first byte bit 0 = 1) never counts as individual.
- R10: Each register stores only the low bits of the write data, up to its own width: 7 for settings, 16 for the high address words and 32 for the low address words. Upper data bits are ignored.
- R11: bus_ack pulses for one cycle per request (bus_cyc and bus_stb high). A write takes effect on the clock edge at which bus_ack is high with bus_we set. Word index 0 is the settings register, with bit 6 = pause-send enable and bit 0 = pause-obey enable. A request with bus_we low changes nothing.
- R12: The pass mask and the programmable addresses are captured when a frame starts. A register write during a frame changes only the decisions of frames that start later.
- R13: A new start-of-frame during an unfinished comparison discards the old frame: no decision is given for it, and the new frame is decided normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in_preamble | input | 1 | Receiver is in its preamble phase |
| rx_byte | input | 8 | Received byte, one per cycle |
| bus_cyc | input | 1 | Register bus cycle |
| bus_stb | input | 1 | Register bus strobe |
| bus_we | input | 1 | Register bus write enable |
| bus_adr | input | 8 | Register bus byte address (word index in bits 7:2) |
| bus_wdat | input | 32 | Register bus write data |
| bus_ack | output | 1 | Register bus acknowledge |
| cfg_pause_send_en | output | 1 | Settings bit 6 |
| cfg_pause_obey_en | output | 1 | Settings bit 0 |
| frame_keep | output | 1 | Keep flag, valid with frame_valid |
| frame_valid | output | 1 | One-cycle decision strobe |

## Verification
A matcher whose byte counter drifts shows up as a decision strobe that arrives off its fixed distance from the 0xD5 byte, or that never arrives. The scoreboard tags each frame with its start cycle, so this is caught on the first frame. A wrongly latched match flag or mask bit flips frame_keep on the very next frame that exercises that class. For this reason the stimulus enables each class on its own and drives near-miss addresses that differ in the first byte, in the last byte, or in a single bit. A start pulse that fails to restart the matchers leaves a stale decision strobe, which the monitor counts as unexpected.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int BYTE_W     = 8;
  localparam int MAC_BYTES  = 6;
  localparam int MAC_W      = BYTE_W * MAC_BYTES;
  localparam int NCLS       = 5;
  localparam int SET_W      = 7;

  // class indices, aligned with settings bits 1..5
  localparam int CL_INDIV = 0;
  localparam int CL_PAUSE = 1;
  localparam int CL_BCAST = 2;
  localparam int CL_MCAST = 3;
  localparam int CL_UCAST = 4;

  localparam logic [BYTE_W-1:0] SFD_BYTE    = 8'hD5;
  localparam logic [SET_W-1:0]  SET_DEFAULT = 7'b0111011;
  localparam logic [MAC_W-1:0]  BCAST_MAC   = 48'hFFFF_FFFF_FFFF;
  localparam logic [MAC_W-1:0]  PAUSE_MAC   = 48'h0180_C200_0001;

  typedef logic [NCLS-1:0] cls_vec_t;
endpackage

// File: rtl/rdf_regbank.sv
module rdf_regbank #(
  parameter int BUS_DW = 32,
  parameter int IDX_W  = 6,
  parameter int MAC_W  = rdf_pkg::MAC_W,
  parameter int SET_W  = rdf_pkg::SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [BUS_DW-1:0] bus_wdat,
  output logic              bus_ack,
  output logic [SET_W-1:0]  settings,
  output logic [MAC_W-1:0]  ucast_mac,
  output logic [MAC_W-1:0]  mcast_mac
);
  localparam int HI_W = MAC_W - BUS_DW;
  localparam logic [IDX_W-1:0] IX_SET  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_UC_H = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_UC_L = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_MC_H = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_MC_L = IDX_W'(4);

  logic             ack_q, ack_d;
  logic [SET_W-1:0] set_q, set_d;
  logic [MAC_W-1:0] uc_q, uc_d, mc_q, mc_d;
  logic             wr_en;

  always_comb begin
    ack_d = bus_cyc & bus_stb & ~ack_q;
    wr_en = bus_cyc & bus_stb & bus_we & ack_q;
    set_d = set_q;
    uc_d  = uc_q;
    mc_d  = mc_q;
    if (wr_en) begin
      case (word_idx)
        IX_SET:  set_d = bus_wdat[SET_W-1:0];
        IX_UC_H: uc_d[MAC_W-1:BUS_DW] = bus_wdat[HI_W-1:0];
        IX_UC_L: uc_d[BUS_DW-1:0]     = bus_wdat;
        IX_MC_H: mc_d[MAC_W-1:BUS_DW] = bus_wdat[HI_W-1:0];
        IX_MC_L: mc_d[BUS_DW-1:0]     = bus_wdat;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      set_q <= rdf_pkg::SET_DEFAULT;
      uc_q  <= '0;
      mc_q  <= '0;
    end else begin
      ack_q <= ack_d;
      set_q <= set_d;
      uc_q  <= uc_d;
      mc_q  <= mc_d;
    end
  end

  assign bus_ack   = ack_q;
  assign settings  = set_q;
  assign ucast_mac = uc_q;
  assign mcast_mac = mc_q;
endmodule

// File: rtl/rdf_exact_match.sv
module rdf_exact_match #(
  parameter int BYTE_W    = rdf_pkg::BYTE_W,
  parameter int MAC_BYTES = rdf_pkg::MAC_BYTES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [BYTE_W-1:0]           data,
  input  logic [BYTE_W*MAC_BYTES-1:0] target,
  output logic                        done,
  output logic                        match
);
  localparam int MW  = BYTE_W * MAC_BYTES;
  localparam int CW  = $clog2(MAC_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(MAC_BYTES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit_q, hit_d;
  logic [MW-1:0] tgt_q, tgt_d;
  logic          cnt_en;

  function automatic logic [BYTE_W-1:0] pick(input logic [MW-1:0] a, input int k);
    return a[MW-1-BYTE_W*k -: BYTE_W];
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    hit_d  = hit_q;
    tgt_d  = tgt_q;
    cnt_en = (cnt_q != '0);
    if (start) begin
      cnt_d = CW'(1);
      hit_d = (data == pick(target, 0));
      tgt_d = target;
    end else if (cnt_en && cnt_q != LAST) begin
      cnt_d = cnt_q + CW'(1);
      hit_d = hit_q & (data == pick(tgt_q, int'(cnt_q)));
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
      tgt_q <= tgt_d;
    end
  end

  assign done  = (cnt_q == LAST);
  assign match = done & hit_q;
endmodule

// File: rtl/rdf_indiv_match.sv
module rdf_indiv_match #(
  parameter int MAC_BYTES = rdf_pkg::MAC_BYTES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic group_bit,
  output logic done,
  output logic match
);
  localparam int SW = $clog2(MAC_BYTES + 2);
  localparam logic [SW-1:0] ST_IDLE = '0;
  localparam logic [SW-1:0] ST_HIT  = SW'(MAC_BYTES);
  localparam logic [SW-1:0] ST_GRP  = SW'(MAC_BYTES + 1);

  logic [SW-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start) begin
      st_d = group_bit ? ST_GRP : SW'(1);
    end else if (st_q == ST_HIT || st_q == ST_GRP) begin
      st_d = ST_IDLE;
    end else if (st_q != ST_IDLE) begin
      st_d = st_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign match = (st_q == ST_HIT);
  assign done  = (st_q == ST_HIT) | (st_q == ST_GRP);
endmodule

// File: rtl/rdf_decide.sv
module rdf_decide #(
  parameter int NCLS = rdf_pkg::NCLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NCLS-1:0] pass_mask,
  input  logic [NCLS-1:0] done_vec,
  input  logic [NCLS-1:0] match_vec,
  output logic            valid,
  output logic            keep
);
  logic            armed_q, armed_d;
  logic [NCLS-1:0] seen_q, seen_d, hits_q, hits_d, mask_q, mask_d;
  logic            valid_q, valid_d, keep_q, keep_d;
  logic [NCLS-1:0] seen_all, hits_all;

  always_comb begin
    seen_all = seen_q | done_vec;
    hits_all = hits_q | (done_vec & match_vec);
    armed_d  = armed_q;
    seen_d   = seen_q;
    hits_d   = hits_q;
    mask_d   = mask_q;
    valid_d  = 1'b0;
    keep_d   = 1'b0;
    if (start) begin
      armed_d = 1'b1;
      seen_d  = '0;
      hits_d  = '0;
      mask_d  = pass_mask;
    end else if (armed_q) begin
      seen_d = seen_all;
      hits_d = hits_all;
      if (&seen_all) begin
        armed_d = 1'b0;
        valid_d = 1'b1;
        keep_d  = |(hits_all & mask_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= '0;
      hits_q  <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
      keep_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      seen_q  <= seen_d;
      hits_q  <= hits_d;
      mask_q  <= mask_d;
      valid_q <= valid_d;
      keep_q  <= keep_d;
    end
  end

  assign valid = valid_q;
  assign keep  = keep_q;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int BYTE_W    = rdf_pkg::BYTE_W,
  parameter int MAC_BYTES = rdf_pkg::MAC_BYTES,
  parameter int BUS_DW    = 32,
  parameter int BUS_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in_preamble,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_adr,
  input  logic [BUS_DW-1:0] bus_wdat,
  output logic              bus_ack,
  output logic              cfg_pause_send_en,
  output logic              cfg_pause_obey_en,
  output logic              frame_keep,
  output logic              frame_valid
);
  import rdf_pkg::*;

  localparam int MW    = BYTE_W * MAC_BYTES;
  localparam int IDX_W = BUS_AW - 2;

  logic [SET_W-1:0] settings;
  logic [MW-1:0]    ucast_mac, mcast_mac;
  logic             start_pulse, start_d;
  cls_vec_t         done_vec, match_vec, pass_mask;
  logic [MW-1:0]    tgt [1:NCLS-1];
  logic             unused_lanes;

  assign unused_lanes = ^bus_adr[1:0];

  rdf_regbank #(.BUS_DW(BUS_DW), .IDX_W(IDX_W), .MAC_W(MW), .SET_W(SET_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .word_idx(bus_adr[BUS_AW-1:2]), .bus_wdat(bus_wdat), .bus_ack(bus_ack),
    .settings(settings), .ucast_mac(ucast_mac), .mcast_mac(mcast_mac)
  );

  // start pulse: one cycle after the delimiter is seen in the preamble
  always_comb start_d = rx_in_preamble & (rx_byte == SFD_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_pulse <= 1'b0;
    else        start_pulse <= start_d;
  end

  assign tgt[CL_PAUSE] = PAUSE_MAC;
  assign tgt[CL_BCAST] = BCAST_MAC;
  assign tgt[CL_MCAST] = mcast_mac;
  assign tgt[CL_UCAST] = ucast_mac;

  rdf_indiv_match #(.MAC_BYTES(MAC_BYTES)) u_indiv (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .group_bit(rx_byte[0]),
    .done(done_vec[CL_INDIV]), .match(match_vec[CL_INDIV])
  );

  for (genvar c = 1; c < NCLS; c++) begin : g_exact
    rdf_exact_match #(.BYTE_W(BYTE_W), .MAC_BYTES(MAC_BYTES)) u_em (
      .clk(clk), .rst_n(rst_n), .start(start_pulse), .data(rx_byte),
      .target(tgt[c]), .done(done_vec[c]), .match(match_vec[c])
    );
  end

  assign pass_mask = settings[NCLS:1];

  rdf_decide #(.NCLS(NCLS)) u_decide (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .pass_mask(pass_mask),
    .done_vec(done_vec), .match_vec(match_vec), .valid(frame_valid), .keep(frame_keep)
  );

  assign cfg_pause_send_en = settings[SET_W-1];
  assign cfg_pause_obey_en = settings[0];
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
  parameter int MAC_BYTES = rdf_pkg::MAC_BYTES
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_in_preamble,
  input logic [7:0] rx_byte,
  input logic       bus_cyc,
  input logic       bus_stb,
  input logic       bus_ack,
  input logic       frame_valid,
  input logic       frame_keep,
  input logic       start_pulse,
  input logic       indiv_done,
  input logic       indiv_match,
  input logic       ucast_done
);
  logic [4:0] since_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_go <= '0;
    else if (start_pulse)      since_go <= 5'd1;
    else if (since_go != '1)   since_go <= since_go + 5'd1;
  end

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(rx_in_preamble && rx_byte == 8'hD5));
  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  // R3
  keep_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_keep |-> frame_valid);
  // R3
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> since_go == 5'(MAC_BYTES + 1));
  // R7
  exact_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ucast_done |-> since_go == 5'(MAC_BYTES));
  // R4
  indiv_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    indiv_match |-> since_go == 5'(MAC_BYTES));
  // R9
  indiv_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (indiv_done && !indiv_match) |-> since_go == 5'd1);
  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  // R11
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_cyc && bus_stb));
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.MAC_BYTES(MAC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_in_preamble(rx_in_preamble), .rx_byte(rx_byte),
  .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_ack(bus_ack),
  .frame_valid(frame_valid), .frame_keep(frame_keep), .start_pulse(start_pulse),
  .indiv_done(done_vec[0]), .indiv_match(match_vec[0]), .ucast_done(done_vec[4])
);

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_in_preamble;
  logic [7:0]  rx_byte;
  logic        bus_cyc, bus_stb, bus_we;
  logic [7:0]  bus_adr;
  logic [31:0] bus_wdat;
  logic        bus_ack, cfg_pause_send_en, cfg_pause_obey_en, frame_keep, frame_valid;

  rx_dest_filter dut (
    .clk(clk), .rst_n(rst_n), .rx_in_preamble(rx_in_preamble), .rx_byte(rx_byte),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdat(bus_wdat), .bus_ack(bus_ack), .cfg_pause_send_en(cfg_pause_send_en),
    .cfg_pause_obey_en(cfg_pause_obey_en), .frame_keep(frame_keep), .frame_valid(frame_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit    keep;
    int    t0;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: pops expected decisions as strobes appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && frame_valid === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 or R13", "unexpected decision strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(frame_keep == e.keep, e.tag, "keep", int'(frame_keep), int'(e.keep));
        check(cyc - e.t0 == LATENCY, "R3", "decision latency", cyc - e.t0, LATENCY);
      end
    end
  end

  task automatic drv(input logic pre, input logic [7:0] b);
    @(negedge clk);
    rx_in_preamble = pre;
    rx_byte = b;
  endtask

  task automatic send_frame(input logic [47:0] da, input int npre, input bit exp_keep,
                            input bit expect_dec, input string tag);
    for (int i = 0; i < npre; i++) drv(1'b1, 8'h55);
    drv(1'b1, 8'hD5);
    if (expect_dec) q.push_back('{exp_keep, cyc, tag});
    for (int i = 0; i < 6; i++) drv(1'b0, da[47-8*i -: 8]);
    for (int i = 0; i < 4; i++) drv(1'b0, 8'hA5);
    for (int i = 0; i < 6; i++) drv(1'b0, 8'h00);
  endtask

  task automatic bus_access(input logic we, input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we;
    bus_adr = {idx, 2'b00}; bus_wdat = d;
    do @(negedge clk); while (bus_ack !== 1'b1);
    @(negedge clk);
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] d);
    bus_access(1'b1, idx, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R3", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_in_preamble = 1'b0; rx_byte = 8'h00;
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0; bus_adr = '0; bus_wdat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(frame_valid == 1'b0, "R1", "frame_valid after reset", int'(frame_valid), 0);
    check(frame_keep == 1'b0, "R1", "frame_keep after reset", int'(frame_keep), 0);
    check(cfg_pause_send_en == 1'b0, "R1", "pause send default", int'(cfg_pause_send_en), 0);
    check(cfg_pause_obey_en == 1'b1, "R1", "pause obey default", int'(cfg_pause_obey_en), 1);

    // default mask: individual, bcast, mcast, ucast on; pause off
    send_frame(48'h0211_2233_4455, 2, 1'b1, 1'b1, "R4");
    send_frame(48'hFEFF_FFFF_FFFF, 2, 1'b1, 1'b1, "R4");
    send_frame(48'hFFFF_FFFF_FFFF, 2, 1'b1, 1'b1, "R5");
    send_frame(48'h0180_C200_0001, 2, 1'b0, 1'b1, "R6");
    send_frame(48'h0300_0000_0000, 2, 1'b0, 1'b1, "R9");

    // R2: delimiter outside preamble starts nothing
    drv(1'b0, 8'hD5);
    for (int i = 0; i < 6; i++) drv(1'b0, 8'hFF);
    for (int i = 0; i < 12; i++) drv(1'b0, 8'h00);
    check(q.size() == 0, "R2", "pending after non-preamble delimiter", q.size(), 0);

    // unicast only; address still at reset value zero
    wr(6'd0, 32'h0000_0020);
    check(cfg_pause_send_en == 1'b0 && cfg_pause_obey_en == 1'b0, "R11", "cfg bits after write",
          int'({cfg_pause_send_en, cfg_pause_obey_en}), 0);
    send_frame(48'h0000_0000_0000, 2, 1'b1, 1'b1, "R1");
    send_frame(48'h0211_2233_4455, 2, 1'b0, 1'b1, "R9");

    wr(6'd1, 32'hFFFF_000A);   // R10 upper bits dropped
    wr(6'd2, 32'h3501_0203);
    send_frame(48'h000A_3501_0203, 2, 1'b1, 1'b1, "R7");
    send_frame(48'h000A_3501_0204, 2, 1'b0, 1'b1, "R7");
    send_frame(48'h010A_3501_0203, 2, 1'b0, 1'b1, "R7");
    send_frame(48'hFFFF_000A_3501, 2, 1'b0, 1'b1, "R10");

    // multicast only
    wr(6'd0, 32'h0000_0010);
    wr(6'd3, 32'h0000_0100);
    wr(6'd4, 32'h5E00_00FB);
    send_frame(48'h0100_5E00_00FB, 2, 1'b1, 1'b1, "R8");
    send_frame(48'h0100_5E00_00FC, 2, 1'b0, 1'b1, "R8");
    send_frame(48'hFFFF_FFFF_FFFF, 2, 1'b0, 1'b1, "R9");

    // pause only
    wr(6'd0, 32'h0000_0004);
    send_frame(48'h0180_C200_0001, 2, 1'b1, 1'b1, "R6");
    send_frame(48'hFFFF_FFFF_FFFF, 2, 1'b0, 1'b1, "R9");

    // broadcast only
    wr(6'd0, 32'h0000_0008);
    send_frame(48'hFFFF_FFFF_FFFF, 2, 1'b1, 1'b1, "R5");
    send_frame(48'hFFFF_FFFF_FFFE, 2, 1'b0, 1'b1, "R5");

    // R11 request without write changes nothing
    bus_access(1'b0, 6'd0, 32'h0000_0000);
    send_frame(48'hFFFF_FFFF_FFFF, 2, 1'b1, 1'b1, "R11");

    // R10 settings keep only the low seven bits
    wr(6'd0, 32'hFFFF_FF80);
    check(cfg_pause_send_en == 1'b0 && cfg_pause_obey_en == 1'b0, "R10", "cfg bits after wide write",
          int'({cfg_pause_send_en, cfg_pause_obey_en}), 0);
    send_frame(48'hFFFF_FFFF_FFFF, 2, 1'b0, 1'b1, "R10");
    wr(6'd0, 32'h0000_0041);
    check(cfg_pause_send_en == 1'b1 && cfg_pause_obey_en == 1'b1, "R11", "cfg bits set",
          int'({cfg_pause_send_en, cfg_pause_obey_en}), 3);

    // R12 write during a frame applies to later frames only
    wr(6'd0, 32'h0000_0020);
    fork
      send_frame(48'h000A_3501_0203, 2, 1'b1, 1'b1, "R12");
      begin
        repeat (5) @(negedge clk);
        wr(6'd0, 32'h0000_0000);
      end
    join
    send_frame(48'h000A_3501_0203, 2, 1'b0, 1'b1, "R12");

    // R13 restart abandons the partial frame
    wr(6'd0, 32'h0000_0002);
    drv(1'b1, 8'h55);
    drv(1'b1, 8'hD5);
    drv(1'b0, 8'h02);
    drv(1'b0, 8'h11);
    drv(1'b0, 8'h22);
    send_frame(48'h0311_2233_4455, 0, 1'b0, 1'b1, "R13");
    send_frame(48'h0211_2233_4455, 1, 1'b1, 1'b1, "R13");

    // R9 several classes enabled together
    wr(6'd0, 32'h0000_003E);
    send_frame(48'h0180_C200_0001, 2, 1'b1, 1'b1, "R9");
    send_frame(48'h0300_0000_0001, 2, 1'b0, 1'b1, "R9");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R3", "decisions outstanding at end", q.size(), 0);
    finished = 1;
    summary();
  end
endmodule